// File: doc/BRIEF.md
# Split-Cycle 8-bit PWM Generator

This block turns an 8-bit duty value into a pulse-width-modulated output. It does not produce one long 256-slot period. Instead it divides each full period into equal sub-cycles that all carry nearly the same high time, so the ripple frequency at the output is two or four times higher than a plain 8-bit PWM would give. The duty value splits into two parts. The upper bits set the base high time that every sub-cycle receives. The lower bits set how many of the leading sub-cycles receive one extra high slot. A mode bit selects either four sub-cycles of 64 slots each or two sub-cycles of 128 slots each.

Slots advance on a tick taken from a selectable source: every system clock, every fourth system clock, or a pulse from a slower clock domain that has already been synchronised. A fourth setting stops the tick, and the output then holds its level. The duty value and the mode are captured only when a new period begins. The output reaches the pin only while the function enable and the port data bit are both set.

The controller is a three-state machine. PS_IDLE is entered at reset and left on the first tick (transition START). PS_HIGH and PS_LOW mark the level of the current slot. The transitions between them are HOLD_HIGH, FALL (high time used up), RISE (a new sub-cycle or period begins with a non-zero high time) and HOLD_LOW.

Top module: `pwm_split_gen`

## Requirements
- R1: With `mode_sel`=1 (7+1 split), the period has two sub-cycles of 128 slots. Sub-cycle i (i=0,1) is high for duty[7:1]+1 slots when i < duty[0], and for duty[7:1] slots otherwise.
- R2: With `mode_sel`=0 (6+2 split), the period has four sub-cycles of 64 slots. Sub-cycle i (i=0..3) is high for duty[7:2]+1 slots when i < duty[1:0], and for duty[7:2] slots otherwise.
- R3: Every sub-cycle begins high when its high time is non-zero, stays high for exactly that many slots, and is low for the rest of the sub-cycle.
- R4: A duty value of 0 keeps the output low for the whole period in both modes.
- R5: The duty value and the mode are captured only on the tick that begins a period. A change in the middle of a period first has effect on the next period.
- R6: With `clk_src`=0, the slot position advances on every clock.
- R7: With `clk_src`=1, the slot position advances once every 4 clocks. The first advance comes on the 4th rising edge after reset is released.
- R8: With `clk_src`=2, the slot position advances on each rising edge at which `slow_tick` is 1.
- R9: With `clk_src`=3, no tick occurs. The position and the output level hold.
- R10: `pwm_pin` shows the modulated level only while both `pwm_fn_en` and `port_bit` are 1. Otherwise it is 0.
- R11: During reset `pwm_pin` is 0 and the block is idle. The first tick after reset begins a period at slot 0 using the duty value and mode present at that tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_src | input | 2 | Slot tick source: 0 every clock, 1 every 4th clock, 2 slow_tick, 3 stopped |
| slow_tick | input | 1 | Synchronised pulse from the slow clock domain |
| duty | input | 8 | Duty value |
| mode_sel | input | 1 | 0: four sub-cycles (6+2), 1: two sub-cycles (7+1) |
| pwm_fn_en | input | 1 | Selects the PWM function for the pin |
| port_bit | input | 1 | Port data bit; 0 forces the pin low |
| pwm_pin | output | 1 | PWM output |

## Verification
The case hardest to reach from the ports is a duty and mode write that lands in the middle of a period, at a slot where the old value and the new value would give different levels. No status output shows the current slot. The bench therefore counts every tick it has caused since reset, for each tick source, and rebuilds the slot position from that count. It then writes the new value at a chosen position and checks the rest of the period against the old value. Stopping the tick while the output is high, and starting the divide-by-4 source from a known reset phase, use the same tick accounting.

// File: rtl/pwm_split_pkg.sv
package pwm_split_pkg;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_HIGH = 2'd1,
        PS_LOW  = 2'd2
    } pwm_state_e;

    typedef enum logic [1:0] {
        CSRC_FSYS = 2'd0,
        CSRC_DIV  = 2'd1,
        CSRC_SLOW = 2'd2,
        CSRC_OFF  = 2'd3
    } clk_src_e;

endpackage

// File: rtl/pwm_tick_sel.sv
module pwm_tick_sel #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src,
    input  logic       slow_tick,
    output logic       tick
);
    import pwm_split_pkg::*;

    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;
    clk_src_e      src_e;

    assign src_e = clk_src_e'(src);

    // free-running divider, phase known from reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_q == DIV_LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    always_comb begin
        unique case (src_e)
            CSRC_FSYS: tick = 1'b1;
            CSRC_DIV:  tick = (div_q == DIV_LAST);
            CSRC_SLOW: tick = slow_tick;
            default:   tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwm_slot_calc.sv
module pwm_slot_calc #(
    parameter int DUTY_W = 8
) (
    input  logic [DUTY_W-1:0] duty,
    input  logic              mode,
    input  logic [DUTY_W-1:0] pos,
    output logic              slot_high
);
    // index 0: two fraction bits (four sub-cycles), index 1: one fraction bit
    logic [1:0] high_by_mode;

    for (genvar g = 0; g < 2; g++) begin : g_mode
        localparam int FB = 2 - g;
        localparam int SW = DUTY_W - FB;

        logic [SW-1:0] base;
        logic [SW-1:0] offs;
        logic [FB-1:0] extra;
        logic [FB-1:0] sub;
        logic [SW:0]   high_len;

        assign base     = duty[DUTY_W-1:FB];
        assign extra    = duty[FB-1:0];
        assign sub      = pos[DUTY_W-1:SW];
        assign offs     = pos[SW-1:0];
        assign high_len = {1'b0, base} + {{SW{1'b0}}, (sub < extra)};
        assign high_by_mode[g] = ({1'b0, offs} < high_len);
    end

    assign slot_high = high_by_mode[mode];

endmodule

// File: rtl/pwm_split_fsm.sv
module pwm_split_fsm #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [DUTY_W-1:0] duty,
    input  logic              mode,
    output logic              raw,
    output logic              idle,
    output logic [DUTY_W-1:0] pos_q,
    output logic [DUTY_W-1:0] duty_q
);
    import pwm_split_pkg::*;

    localparam logic [DUTY_W-1:0] POS_LAST = '1;

    pwm_state_e        state_q, state_n;
    logic              mode_q;
    logic              wrap;
    logic [DUTY_W-1:0] pos_n;
    logic [DUTY_W-1:0] duty_n;
    logic              mode_n;
    logic              high_n;

    // a new period begins after idle or after the last slot
    assign wrap   = (state_q == PS_IDLE) || (pos_q == POS_LAST);
    assign pos_n  = wrap ? '0   : pos_q + 1'b1;
    assign duty_n = wrap ? duty : duty_q;
    assign mode_n = wrap ? mode : mode_q;

    pwm_slot_calc #(.DUTY_W(DUTY_W)) u_calc (
        .duty      (duty_n),
        .mode      (mode_n),
        .pos       (pos_n),
        .slot_high (high_n)
    );

    always_comb begin
        state_n = state_q;
        if (tick) begin
            unique case (state_q)
                PS_IDLE: state_n = high_n ? PS_HIGH : PS_LOW;   // START
                PS_HIGH: state_n = high_n ? PS_HIGH : PS_LOW;   // HOLD_HIGH / FALL
                PS_LOW:  state_n = high_n ? PS_HIGH : PS_LOW;   // RISE / HOLD_LOW
                default: state_n = PS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            pos_q   <= '0;
            duty_q  <= '0;
            mode_q  <= 1'b0;
        end else if (tick) begin
            state_q <= state_n;
            pos_q   <= pos_n;
            duty_q  <= duty_n;
            mode_q  <= mode_n;
        end
    end

    always_comb begin
        raw  = (state_q == PS_HIGH);
        idle = (state_q == PS_IDLE);
    end

endmodule

// File: rtl/pwm_split_gen.sv
module pwm_split_gen #(
    parameter int DUTY_W = 8,
    parameter int DIV    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        clk_src,
    input  logic              slow_tick,
    input  logic [DUTY_W-1:0] duty,
    input  logic              mode_sel,
    input  logic              pwm_fn_en,
    input  logic              port_bit,
    output logic              pwm_pin
);
    logic              tick_w;
    logic              raw_w;
    logic              idle_w;
    logic [DUTY_W-1:0] pos_w;
    logic [DUTY_W-1:0] dq_w;

    pwm_tick_sel #(.DIV(DIV)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (clk_src),
        .slow_tick (slow_tick),
        .tick      (tick_w)
    );

    pwm_split_fsm #(.DUTY_W(DUTY_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_w),
        .duty   (duty),
        .mode   (mode_sel),
        .raw    (raw_w),
        .idle   (idle_w),
        .pos_q  (pos_w),
        .duty_q (dq_w)
    );

    assign pwm_pin = raw_w & pwm_fn_en & port_bit;

endmodule

// File: rtl/pwm_split_chk.sv
module pwm_split_chk #(
    parameter int DUTY_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        clk_src,
    input logic              slow_tick,
    input logic [DUTY_W-1:0] duty,
    input logic              pwm_fn_en,
    input logic              port_bit,
    input logic              pwm_pin,
    input logic              tick,
    input logic              raw,
    input logic              idle,
    input logic [DUTY_W-1:0] pos,
    input logic [DUTY_W-1:0] duty_q
);
    logic period_edge;
    assign period_edge = tick && (idle || (pos == '1));

    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (period_edge && duty == '0) |=> !raw); // R4

    AST_PERIOD_STARTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (period_edge && duty != '0) |=> raw); // R3

    AST_POS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !idle) |=> (pos == $past(pos) + 1'b1)); // R6

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick) |=> ($stable(raw) && $stable(pos))); // R9

    AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !(tick && pos == '1)) |=> $stable(duty_q)); // R5

    AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_fn_en || !port_bit) |-> !pwm_pin); // R10

    AST_SRC_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_src == 2'd3) |-> !tick); // R9

    AST_SLOW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_src == 2'd2) |-> (tick == slow_tick)); // R8

endmodule

bind pwm_split_gen pwm_split_chk #(.DUTY_W(DUTY_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_src   (clk_src),
    .slow_tick (slow_tick),
    .duty      (duty),
    .pwm_fn_en (pwm_fn_en),
    .port_bit  (port_bit),
    .pwm_pin   (pwm_pin),
    .tick      (tick_w),
    .raw       (raw_w),
    .idle      (idle_w),
    .pos       (pos_w),
    .duty_q    (dq_w)
);

// File: tb/pwm_split_gen_bench.sv
`timescale 1ns/1ps
module pwm_split_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       slow = 1'b0;
    logic [7:0] drv_d = 8'hFF;
    logic       drv_m = 1'b0;
    logic       en = 1'b1;
    logic       pd = 1'b1;
    logic       pin;

    int   checks = 0;
    int   failures = 0;
    bit   done = 0;
    int   e = 0;
    int   nt = 0;
    int   p = 0;
    logic [7:0] lat_d = 8'h00;
    logic       lat_m = 1'b0;

    always #2.5 clk = ~clk;

    pwm_split_gen u_pwm_split_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_src   (sel),
        .slow_tick (slow),
        .duty      (drv_d),
        .mode_sel  (drv_m),
        .pwm_fn_en (en),
        .port_bit  (pd),
        .pwm_pin   (pin)
    );

    function automatic logic model(input logic [7:0] d, input logic m, input int pp);
        int sub, c, base, ex;
        if (m) begin
            sub = pp / 128; c = pp % 128; base = int'(d) / 2; ex = int'(d) % 2;
        end else begin
            sub = pp / 64;  c = pp % 64;  base = int'(d) / 4; ex = int'(d) % 4;
        end
        return (c < base + ((sub < ex) ? 1 : 0));
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s pin=%0b expected=%0b slot=%0d duty=%02h mode=%0b",
                     tag, act, exp, p, lat_d, lat_m);
        end
    endtask

    // one clock: account for the tick taken at the edge, then check
    task automatic step(input string tag);
        logic tk;
        logic exp;
        @(negedge clk);
        e++;
        tk = (sel == 2'd0) || (sel == 2'd1 && (e % 4) == 0) || (sel == 2'd2 && slow);
        if (tk) begin
            nt++;
            p = (nt - 1) % 256;
            if (p == 0) begin
                lat_d = drv_d;
                lat_m = drv_m;
            end
        end
        exp = (nt > 0) && model(lat_d, lat_m, p) && en && pd;
        check(pin, exp, tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic do_reset(input logic [1:0] s);
        @(negedge clk);
        rst_n = 1'b0;
        sel = s;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(pin, 1'b0, "R11");
        end
        rst_n = 1'b1;
        e = 0;
        nt = 0;
        p = 0;
    endtask

    initial begin
        // reset state and first period (R11)
        drv_d = 8'hFF; drv_m = 1'b1; en = 1'b1; pd = 1'b1;
        do_reset(2'd0);
        step("R11");
        run(255, "R11");

        // sweep of duty values in both modes, one period each
        for (int m = 0; m < 2; m++) begin
            for (int d = 0; d < 256; d += 5) begin
                drv_d = 8'(d); drv_m = m[0];
                run(256, m ? "R1" : "R2");
            end
            drv_d = 8'hFF; drv_m = m[0];
            run(256, m ? "R1" : "R2");
        end

        // shape of an uneven split (R3)
        drv_d = 8'h0B; drv_m = 1'b0;
        run(256, "R3");
        drv_d = 8'h03; drv_m = 1'b1;
        run(256, "R3");

        // zero duty in both modes (R4)
        drv_d = 8'h00; drv_m = 1'b0;
        run(256, "R4");
        drv_m = 1'b1;
        run(256, "R4");

        // mid-period write takes effect next period (R5)
        drv_d = 8'h40; drv_m = 1'b1;
        run(356, "R5");
        drv_d = 8'hC0; drv_m = 1'b0;
        run(156, "R5");
        run(256, "R5");

        // output gating (R10)
        drv_d = 8'hFF; drv_m = 1'b1;
        en = 1'b0;
        run(256, "R10");
        en = 1'b1; pd = 1'b0;
        run(256, "R10");
        pd = 1'b1;
        run(256, "R10");

        // every-clock source, fresh start (R6)
        drv_d = 8'h0B; drv_m = 1'b0;
        do_reset(2'd0);
        run(2, "R6");
        // stop the tick while the output is high (R9)
        sel = 2'd3;
        run(20, "R9");
        sel = 2'd0;
        run(30, "R6");

        // stopped source straight after reset (R9)
        drv_d = 8'hFF; drv_m = 1'b1;
        do_reset(2'd3);
        run(40, "R9");

        // divide-by-4 source (R7)
        drv_d = 8'h80; drv_m = 1'b1;
        do_reset(2'd1);
        run(1100, "R7");
        drv_d = 8'h0B; drv_m = 1'b0;
        do_reset(2'd1);
        run(1100, "R7");

        // slow-domain pulses (R8)
        drv_d = 8'h0B; drv_m = 1'b0;
        do_reset(2'd2);
        for (int i = 0; i < 900; i++) begin
            step("R8");
            slow = ((i % 3) == 0);
        end
        slow = 1'b0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule